// File: doc/BRIEF.md
# Strided Indexed Register Read Port

This block lets a register bus read a set of small per-ring state memories (16 entries each, one entry per ring) without giving each entry its own address. Each memory is visible at a single bus address. Which entry a read returns is chosen by a stored pointer held in a separate pointer register, and after each memory read the pointer moves forward by a programmable stride. Software writes the pointer register once, for example with a start of 0 and a stride of 1, and then reads the same memory address repeatedly to dump every entry in order. All memory addresses share the one pointer register.

The memories are filled through a dedicated write port, separate from the bus. The bus uses a plain request strobe. Every accepted request gets a single-cycle acknowledge one clock later, and read data is registered and valid alongside that acknowledge.

Top module: `strided_csr_reader`

## Requirements
- R1: Reset clears the pointer, the stride, every memory entry, the acknowledge and the read data to zero.
- R2: A bus write to the pointer address (0x00) loads the pointer from write data bits [7:0] and the stride from bits [15:8]. All other write data bits are ignored.
- R3: A bus read of the pointer address returns the stride in bits [15:8] and the pointer in bits [7:0], with zeros above. It leaves both values unchanged.
- R4: A bus read of memory address 0x10+k (k = 0, 1, 2) returns entry number pointer[3:0] of memory k, zero-extended from 48 to 64 bits.
- R5: After each memory read the pointer becomes (pointer + stride) modulo 256. The stride is unchanged.
- R6: Every request presented on a clock edge is acknowledged by a single-cycle ack one cycle later. The ack is low in any cycle after an edge with no request.
- R7: With pointer 0 and stride 1, back-to-back reads of one memory address (one per cycle) return entries 0, 1, ..., 15 and then wrap to entry 0.
- R8: With stride 0, repeated memory reads return the same entry each time.
- R9: A bus read of any address that is neither the pointer address nor a memory address returns zero and does not move the pointer.
- R10: Bus writes to memory addresses or to unmapped addresses change neither the memories, the pointer nor the stride.
- R11: A write-port write stores the data in entry `mem_waddr` of memory `mem_sel`. A `mem_sel` value of 3 or more is ignored. A bus read of the same entry on the same edge returns the previous contents.
- R12: Pointer bits [7:4] do not affect entry selection. For example, pointers 0x35 and 0x45 both read entry 5.
- R13: Read data is zero in every cycle without ack, and zero with the ack of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Bus request strobe, one request per cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Bus register address |
| req_wdata | input | 64 | Bus write data |
| resp_ack | output | 1 | Acknowledge, one cycle after the request |
| resp_rdata | output | 64 | Registered read data, valid with ack |
| mem_we | input | 1 | Write-port enable |
| mem_sel | input | 2 | Write-port memory select |
| mem_waddr | input | 4 | Write-port entry number |
| mem_wdata | input | 48 | Write-port data |

## Verification
Some behaviours are checked by the bound checker on every clock. These are: the one-cycle ack timing and its absence when idle; the pointer step after a memory read; pointer and stride loading from the write data field; the pointer and stride staying still on pointer reads, unmapped reads and bus writes; the pointer-register read value; and zero data when no ack. Other behaviours depend on memory contents, so only the bench's scenarios can show them. These are: which entry a memory read returns, the sixteen-entry in-order dump with wrap, upper pointer bits being ignored for selection, the old-data result when a bus read and a port write hit the same entry on the same edge, and out-of-range port selects being dropped.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

   typedef enum logic [2:0] {
      RQ_IDLE   = 3'd0,
      RQ_PTR_WR = 3'd1,
      RQ_PTR_RD = 3'd2,
      RQ_MEM_RD = 3'd3,
      RQ_IGN_RD = 3'd4,
      RQ_IGN_WR = 3'd5
   } req_kind_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/scr_decode.sv
`timescale 1ns/1ps
module scr_decode import scr_pkg::*; #(
   parameter int ADDR_W   = 8,
   parameter int NUM_MEMS = 3,
   parameter int MSEL_W   = 2,
   parameter logic [ADDR_W-1:0] PTR_ADDR = '0,
   parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   output req_kind_e         kind,
   output logic [MSEL_W-1:0] mem_num
);

   logic [ADDR_W-1:0] offset;
   logic              hit_ptr;
   logic              hit_mem;

   assign offset  = req_addr - MEM_BASE;
   assign hit_ptr = (req_addr == PTR_ADDR);
   assign hit_mem = (req_addr >= MEM_BASE) && (offset < ADDR_W'(NUM_MEMS));
   assign mem_num = MSEL_W'(offset);

   always_comb begin
      kind = RQ_IDLE;
      if (req_vld) begin
         if (hit_ptr) begin
            kind = req_wr ? RQ_PTR_WR : RQ_PTR_RD;
         end else if (hit_mem) begin
            kind = req_wr ? RQ_IGN_WR : RQ_MEM_RD;
         end else begin
            kind = req_wr ? RQ_IGN_WR : RQ_IGN_RD;
         end
      end
   end

endmodule

// File: rtl/scr_index_reg.sv
`timescale 1ns/1ps
module scr_index_reg #(
   parameter int IDX_W = 8,
   parameter int INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [INC_W-1:0] ld_inc,
   input  logic             step,
   output logic [IDX_W-1:0] idx_q,
   output logic [INC_W-1:0] inc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         inc_q <= '0;
      end else if (load) begin
         idx_q <= ld_idx;
         inc_q <= ld_inc;
      end else if (step) begin
         idx_q <= idx_q + IDX_W'(inc_q);
      end
   end

endmodule

// File: rtl/scr_entry_bank.sv
`timescale 1ns/1ps
module scr_entry_bank #(
   parameter int ENTRIES = 16,
   parameter int MEM_W   = 48,
   parameter int SEL_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_addr,
   input  logic [MEM_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_addr,
   output logic [MEM_W-1:0] rd_data
);

   logic [MEM_W-1:0] cells [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            cells[i] <= '0;
         end
      end else if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/scr_resp.sv
`timescale 1ns/1ps
module scr_resp import scr_pkg::*; #(
   parameter int DATA_W    = 64,
   parameter int MEM_W     = 48,
   parameter int IDX_W     = 8,
   parameter int INC_W     = 8,
   parameter int NUM_MEMS  = 3,
   parameter int MSEL_W    = 2,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  req_kind_e         kind,
   input  logic [MSEL_W-1:0] mem_num,
   input  logic [IDX_W-1:0]  idx,
   input  logic [INC_W-1:0]  inc,
   input  logic [MEM_W-1:0]  bank_data [NUM_MEMS],
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);

   logic [MEM_W-1:0]  bank_pick;
   logic [DATA_W-1:0] sel_data;
   logic              is_read;

   always_comb begin
      bank_pick = '0;
      for (int k = 0; k < NUM_MEMS; k++) begin
         if (mem_num == MSEL_W'(k)) begin
            bank_pick = bank_data[k];
         end
      end
   end

   always_comb begin
      case (kind)
         RQ_PTR_RD: sel_data = DATA_W'({inc, idx});
         RQ_MEM_RD: sel_data = DATA_W'(bank_pick);
         default:   sel_data = '0;
      endcase
   end

   assign is_read = (kind == RQ_PTR_RD) || (kind == RQ_MEM_RD) || (kind == RQ_IGN_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
      end else begin
         ack <= (kind != RQ_IDLE);
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else begin
               rdata <= sel_data;
            end
         end
      end else begin : g_hold_last
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata <= '0;
            end else if (is_read) begin
               rdata <= sel_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/strided_csr_reader.sv
`timescale 1ns/1ps
module strided_csr_reader import scr_pkg::*; #(
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 8,
   parameter int ENTRIES   = 16,
   parameter int MEM_W     = 48,
   parameter int NUM_MEMS  = 3,
   parameter int IDX_W     = 8,
   parameter int INC_W     = 8,
   parameter logic [ADDR_W-1:0] PTR_ADDR = 8'h00,
   parameter logic [ADDR_W-1:0] MEM_BASE = 8'h10,
   parameter bit ZERO_IDLE = 1'b1,
   localparam int SEL_W    = $clog2(ENTRIES),
   localparam int MSEL_W   = sel_width(NUM_MEMS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              resp_ack,
   output logic [DATA_W-1:0] resp_rdata,
   input  logic              mem_we,
   input  logic [MSEL_W-1:0] mem_sel,
   input  logic [SEL_W-1:0]  mem_waddr,
   input  logic [MEM_W-1:0]  mem_wdata
);

   localparam int FIELD_W = IDX_W + INC_W;

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (IDX_W < SEL_W) begin : g_bad_idx_w
         $error("IDX_W must cover the entry select width");
      end
      if (INC_W > IDX_W) begin : g_bad_inc_w
         $error("INC_W must not exceed IDX_W");
      end
      if (MEM_W > DATA_W || FIELD_W > DATA_W) begin : g_bad_data_w
         $error("memory word and pointer fields must fit the bus width");
      end
      if (NUM_MEMS < 1 || (int'(MEM_BASE) + NUM_MEMS) > (1 << ADDR_W)) begin : g_bad_map
         $error("memory address range must fit the address space");
      end
      if (PTR_ADDR >= MEM_BASE && int'(PTR_ADDR) < int'(MEM_BASE) + NUM_MEMS) begin : g_overlap
         $error("pointer address overlaps the memory address range");
      end
   endgenerate

   req_kind_e         kind;
   logic [MSEL_W-1:0] mem_num;
   logic [IDX_W-1:0]  idx_q;
   logic [INC_W-1:0]  inc_q;
   logic [MEM_W-1:0]  bank_rd [NUM_MEMS];

   generate
      if (DATA_W > FIELD_W) begin : g_wdata_spare
         logic wdata_unused;
         assign wdata_unused = ^req_wdata[DATA_W-1:FIELD_W];
      end
   endgenerate

   scr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_MEMS (NUM_MEMS),
      .MSEL_W   (MSEL_W),
      .PTR_ADDR (PTR_ADDR),
      .MEM_BASE (MEM_BASE)
   ) u_decode (
      .req_vld  (req_vld),
      .req_wr   (req_wr),
      .req_addr (req_addr),
      .kind     (kind),
      .mem_num  (mem_num)
   );

   scr_index_reg #(
      .IDX_W (IDX_W),
      .INC_W (INC_W)
   ) u_index (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (kind == RQ_PTR_WR),
      .ld_idx (req_wdata[IDX_W-1:0]),
      .ld_inc (req_wdata[IDX_W +: INC_W]),
      .step   (kind == RQ_MEM_RD),
      .idx_q  (idx_q),
      .inc_q  (inc_q)
   );

   generate
      for (genvar k = 0; k < NUM_MEMS; k++) begin : g_bank
         scr_entry_bank #(
            .ENTRIES (ENTRIES),
            .MEM_W   (MEM_W),
            .SEL_W   (SEL_W)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (mem_we && (mem_sel == MSEL_W'(k))),
            .wr_addr (mem_waddr),
            .wr_data (mem_wdata),
            .rd_addr (idx_q[SEL_W-1:0]),
            .rd_data (bank_rd[k])
         );
      end
   endgenerate

   scr_resp #(
      .DATA_W    (DATA_W),
      .MEM_W     (MEM_W),
      .IDX_W     (IDX_W),
      .INC_W     (INC_W),
      .NUM_MEMS  (NUM_MEMS),
      .MSEL_W    (MSEL_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (kind),
      .mem_num   (mem_num),
      .idx       (idx_q),
      .inc       (inc_q),
      .bank_data (bank_rd),
      .ack       (resp_ack),
      .rdata     (resp_rdata)
   );

endmodule

// File: rtl/scr_reader_chk.sv
`timescale 1ns/1ps
module scr_reader_chk #(
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 8,
   parameter int NUM_MEMS  = 3,
   parameter int IDX_W     = 8,
   parameter int INC_W     = 8,
   parameter logic [ADDR_W-1:0] PTR_ADDR = 8'h00,
   parameter logic [ADDR_W-1:0] MEM_BASE = 8'h10,
   parameter bit ZERO_IDLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              resp_ack,
   input logic [DATA_W-1:0] resp_rdata,
   input logic [IDX_W-1:0]  idx_q,
   input logic [INC_W-1:0]  inc_q
);

   logic hit_ptr, hit_mem;
   logic is_mem_rd, is_ptr_rd, is_ptr_wr, is_other_rd, is_side_wr;

   assign hit_ptr     = (req_addr == PTR_ADDR);
   assign hit_mem     = (req_addr >= MEM_BASE) &&
                        ((req_addr - MEM_BASE) < ADDR_W'(NUM_MEMS));
   assign is_mem_rd   = req_vld && !req_wr && hit_mem;
   assign is_ptr_rd   = req_vld && !req_wr && hit_ptr;
   assign is_ptr_wr   = req_vld &&  req_wr && hit_ptr;
   assign is_other_rd = req_vld && !req_wr && !hit_ptr && !hit_mem;
   assign is_side_wr  = req_vld &&  req_wr && !hit_ptr;

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (idx_q == '0 && inc_q == '0 && !resp_ack));

   p_load_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_ptr_wr |=> (idx_q == $past(req_wdata[IDX_W-1:0]) &&
                     inc_q == $past(req_wdata[IDX_W +: INC_W])));

   p_ptr_read_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_ptr_rd |=> ($stable(idx_q) && $stable(inc_q)));

   p_ptr_read_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_ptr_rd |=> (resp_rdata == DATA_W'({$past(inc_q), $past(idx_q)})));

   p_stride_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_mem_rd |=> (idx_q == $past(idx_q) + IDX_W'($past(inc_q)) && $stable(inc_q)));

   p_ack_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> resp_ack);

   p_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !resp_ack);

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      is_other_rd |=> (resp_rdata == '0 && $stable(idx_q)));

   p_write_no_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_side_wr |=> ($stable(idx_q) && $stable(inc_q)));

   generate
      if (ZERO_IDLE) begin : g_idle_chk
         p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !resp_ack |-> (resp_rdata == '0));
      end
   endgenerate

endmodule

bind strided_csr_reader scr_reader_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_MEMS  (NUM_MEMS),
   .IDX_W     (IDX_W),
   .INC_W     (INC_W),
   .PTR_ADDR  (PTR_ADDR),
   .MEM_BASE  (MEM_BASE),
   .ZERO_IDLE (ZERO_IDLE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_vld    (req_vld),
   .req_wr     (req_wr),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .resp_ack   (resp_ack),
   .resp_rdata (resp_rdata),
   .idx_q      (idx_q),
   .inc_q      (inc_q)
);

// File: tb/strided_csr_reader_test.sv
`timescale 1ns/1ps
module strided_csr_reader_test;

   localparam int NM = 3;
   localparam int NE = 16;
   localparam logic [7:0] A_PTR = 8'h00;
   localparam logic [7:0] A_MEM = 8'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic        req_wr = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        resp_ack;
   logic [63:0] resp_rdata;
   logic        mem_we = 1'b0;
   logic [1:0]  mem_sel = '0;
   logic [3:0]  mem_waddr = '0;
   logic [47:0] mem_wdata = '0;

   always #2.5 clk = ~clk;

   strided_csr_reader uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .resp_ack(resp_ack),
      .resp_rdata(resp_rdata), .mem_we(mem_we), .mem_sel(mem_sel),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [47:0] m_mem [NM][NE];
   logic [7:0]  m_idx = '0;
   logic [7:0]  m_inc = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model_bus(input bit wr, input logic [7:0] a,
                                              input logic [63:0] d);
      logic [63:0] r;
      r = '0;
      if (a == A_PTR) begin
         if (wr) begin
            m_idx = d[7:0];
            m_inc = d[15:8];
         end else begin
            r = {48'b0, m_inc, m_idx};
         end
      end else if (a >= A_MEM && a < A_MEM + NM) begin
         if (!wr) begin
            r = {16'b0, m_mem[a - A_MEM][m_idx[3:0]]};
            m_idx = m_idx + m_inc;
         end
      end
      return r;
   endfunction

   task automatic bus_op(input string tag, input bit wr, input logic [7:0] a,
                         input logic [63:0] d);
      logic [63:0] exp;
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      exp = model_bus(wr, a, d);
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
      chk({tag, " R6 ack"}, 64'(resp_ack), 64'd1);
      if (wr) chk({tag, " R13 write data zero"}, resp_rdata, 64'd0);
      else    chk(tag, resp_rdata, exp);
   endtask

   task automatic port_write(input int k, input int e, input logic [47:0] v);
      @(negedge clk);
      mem_we = 1'b1; mem_sel = 2'(k); mem_waddr = 4'(e); mem_wdata = v;
      if (k < NM) m_mem[k][e] = v;
      @(negedge clk);
      mem_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] exp_prev;
      logic [47:0] old_v;
      int unsigned seed_val;
      seed_val = $urandom(32'd715);
      for (int k = 0; k < NM; k++)
         for (int e = 0; e < NE; e++) m_mem[k][e] = '0;

      // R1: reset state
      repeat (4) @(negedge clk);
      chk("R1 ack in reset", 64'(resp_ack), 64'd0);
      chk("R1 rdata in reset", resp_rdata, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 idle ack low", 64'(resp_ack), 64'd0);
      bus_op("R1 pointer after reset", 1'b0, A_PTR, 64'd0);
      bus_op("R1 memory cleared", 1'b0, A_MEM + 8'd1, 64'd0);

      // fill memories through the write port
      for (int k = 0; k < NM; k++)
         for (int e = 0; e < NE; e++)
            port_write(k, e, {8'(k + 1), 8'(e), 32'hC0DE_0000 ^ 32'(k * 97 + e * 13)});

      // R2 / R3: load with junk in spare bits, read back twice
      bus_op("R2 load", 1'b1, A_PTR, 64'hFFFF_FFFF_FFFF_0203);
      bus_op("R2 R3 read pointer", 1'b0, A_PTR, 64'd0);
      bus_op("R3 read pointer again", 1'b0, A_PTR, 64'd0);
      chk("R2 pointer field", 64'(m_idx), 64'h03);

      // R4: one entry from each memory
      bus_op("R4 set", 1'b1, A_PTR, 64'h0000_000A);
      for (int k = 0; k < NM; k++)
         bus_op("R4 memory read", 1'b0, A_MEM + 8'(k), 64'd0);

      // R7: back-to-back dump with wrap
      bus_op("R7 set", 1'b1, A_PTR, 64'h0100);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = A_MEM + 8'd2;
      exp_prev = model_bus(1'b0, A_MEM + 8'd2, 64'd0);
      for (int i = 1; i <= 18; i++) begin
         @(negedge clk);
         chk("R6 burst ack", 64'(resp_ack), 64'd1);
         chk("R7 in-order entry", resp_rdata, {16'b0, m_mem[2][(i - 1) % NE]});
         if (i < 18) exp_prev = model_bus(1'b0, A_MEM + 8'd2, 64'd0);
         else req_vld = 1'b0;
      end
      @(negedge clk);
      chk("R6 ack drops after burst", 64'(resp_ack), 64'd0);
      chk("R13 idle data zero", resp_rdata, 64'd0);

      // R12 / R5: upper pointer bits ignored
      bus_op("R12 set", 1'b1, A_PTR, 64'h1035);
      bus_op("R12 entry 5", 1'b0, A_MEM + 8'd1, 64'd0);
      bus_op("R12 entry 5 again", 1'b0, A_MEM + 8'd1, 64'd0);
      bus_op("R5 pointer after stride", 1'b0, A_PTR, 64'd0);
      chk("R5 pointer 0x55", 64'(m_idx), 64'h55);

      // R8: zero stride
      bus_op("R8 set", 1'b1, A_PTR, 64'h0007);
      for (int i = 0; i < 3; i++)
         bus_op("R8 same entry", 1'b0, A_MEM, 64'd0);
      bus_op("R8 pointer unchanged", 1'b0, A_PTR, 64'd0);

      // R5: modulo 256 wrap
      bus_op("R5 set", 1'b1, A_PTR, 64'h03FE);
      bus_op("R5 entry E", 1'b0, A_MEM, 64'd0);
      bus_op("R5 entry 1", 1'b0, A_MEM, 64'd0);
      bus_op("R5 wrapped pointer", 1'b0, A_PTR, 64'd0);

      // R9: unmapped reads
      bus_op("R9 unmapped 0x13", 1'b0, 8'h13, 64'd0);
      bus_op("R9 unmapped 0xFF", 1'b0, 8'hFF, 64'd0);
      bus_op("R9 unmapped 0x01", 1'b0, 8'h01, 64'd0);
      bus_op("R9 pointer unchanged", 1'b0, A_PTR, 64'd0);

      // R10: bus writes with no effect
      bus_op("R10 write memory addr", 1'b1, A_MEM + 8'd1, 64'hDEAD_BEEF_DEAD_BEEF);
      bus_op("R10 write unmapped", 1'b1, 8'h40, 64'h0000_0000_0000_FFFF);
      bus_op("R10 pointer unchanged", 1'b0, A_PTR, 64'd0);
      bus_op("R10 set stride 0", 1'b1, A_PTR, 64'h0002);
      bus_op("R10 memory unchanged", 1'b0, A_MEM + 8'd1, 64'd0);

      // R11: same-edge port write and bus read of one entry
      bus_op("R11 set", 1'b1, A_PTR, 64'h0009);
      old_v = m_mem[0][9];
      @(negedge clk);
      mem_we = 1'b1; mem_sel = 2'd0; mem_waddr = 4'd9; mem_wdata = 48'h1234_5678_9ABC;
      req_vld = 1'b1; req_wr = 1'b0; req_addr = A_MEM;
      @(negedge clk);
      mem_we = 1'b0; req_vld = 1'b0;
      chk("R11 same-edge read returns old", resp_rdata, {16'b0, old_v});
      m_mem[0][9] = 48'h1234_5678_9ABC;
      bus_op("R11 new data visible", 1'b0, A_MEM, 64'd0);
      port_write(3, 9, 48'hFFFF_FFFF_FFFF);
      for (int k = 0; k < NM; k++)
         bus_op("R11 out-of-range select ignored", 1'b0, A_MEM + 8'(k), 64'd0);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int unsigned pick;
         pick = $urandom_range(0, 9);
         case (pick)
            0, 1: port_write($urandom_range(0, 3), $urandom_range(0, 15), 48'($urandom()) ^ {16'($urandom()), 32'h0});
            2:    bus_op("R2 random load", 1'b1, A_PTR, {32'($urandom()), 32'($urandom())});
            3, 4, 5: bus_op("R4 random memory read", 1'b0, A_MEM + 8'($urandom_range(0, NM - 1)), 64'd0);
            6:    bus_op("R3 random pointer read", 1'b0, A_PTR, 64'd0);
            7:    bus_op("R9 random unmapped read", 1'b0, 8'($urandom_range(32, 255)), 64'd0);
            default: bus_op("R10 random side write", 1'b1, A_MEM + 8'($urandom_range(0, 5)), {32'($urandom()), 32'($urandom())});
         endcase
      end
      for (int k = 0; k < NM; k++)
         bus_op("R4 final read", 1'b0, A_MEM + 8'(k), 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule